// File: doc/BRIEF.md
# Power-Down and Clock Gating Controller

This block sequences power for a processing core and its auxiliary units. It drives the enable of an external oscillator and PLL. It holds the core in an internal reset until a programmable settling count has elapsed and the oscillator reports that it is stable. It also applies the low-power settings that firmware chooses. Deep power-down is entered from an active-low pin and stops the oscillator. Leaving it takes two steps in a fixed order: the pin returns high, and then the external reset pin is pulsed.

While the core runs, firmware can apply two warm power modes through write strobes. One slows the core to one active cycle in every 256, using a counter-generated clock enable. The other stops any subset of the auxiliary units, each through its own enable. Both settings return to their defaults whenever the core is not running. That covers deep power-down, the settling wait and a pin reset.

The two pins pass through synchronizers inside the block. All sequencing runs on the free-running block clock, which is reset asynchronously by `arst_n`.

Top module: `pwrdn_clk_ctrl`

## Requirements
- R1: After the internal sequencer enters its wait state, `core_rst_n` stays 0 until STABLE_CYCLES clock cycles have elapsed. With the default two-stage synchronizer, it rises STABLE_CYCLES+3 to STABLE_CYCLES+5 cycles after `ext_rst_n` goes low, if the pin is released early and `osc_stable` is 1. If the count has already finished when `ext_rst_n` returns high, `core_rst_n` rises within 4 cycles.
- R2: Within 4 cycles of `pdwn_n` going low, `osc_en`, `core_rst_n`, `core_ce` and every `unit_ce` bit are 0.
- R3: While `pdwn_n` is low, a pulse on `ext_rst_n` has no effect. Raising `pdwn_n` alone leaves `osc_en` at 0. Only a low pulse on `ext_rst_n` after `pdwn_n` is high sets `osc_en` to 1 and starts the settling wait.
- R4: With the divide setting on, `core_ce` is 1 in exactly one cycle of every 256. With it off and the core running, `core_ce` is 1 in every cycle.
- R5: A write on `fw_stop_wr` loads `fw_stop_mask` in the next cycle. Bit i equal to 1 stops unit i. `unit_ce[i]` equals `core_ce` AND NOT stop bit i.
- R6: Power-down clears the divide setting and all stop bits. After wake-up, `core_ce` is 1 every cycle and `unit_ce` is all ones.
- R7: Firmware writes made while `core_rst_n` is 0 are ignored.
- R8: While `osc_stable` is 0, `core_rst_n` stays 0, even after the settling count has finished.
- R9: A low level on `ext_rst_n` while the core runs returns `core_rst_n` to 0 and restarts the settling wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| pdwn_n | input | 1 | Power-down pin, active low, asynchronous |
| osc_stable | input | 1 | Oscillator and PLL report stable operation |
| fw_div_wr | input | 1 | Firmware write strobe for the divide setting |
| fw_div_on | input | 1 | 1 selects the divide-by-256 core clock enable |
| fw_stop_wr | input | 1 | Firmware write strobe for the unit stop mask |
| fw_stop_mask | input | NUM_UNITS | 1 in bit i stops unit i |
| osc_en | output | 1 | Enable for the oscillator and PLL |
| core_rst_n | output | 1 | Internal active-low core reset |
| core_ce | output | 1 | Core clock enable |
| unit_ce | output | NUM_UNITS | Per-unit clock enables |

## Verification
A corrupted sequencer state shows up on `osc_en` and `core_rst_n` within a few cycles of a pin change. An early wake from power-down or a premature reset release appears as a transition on those pins at the wrong cycle. A wrong divider count shows as a gap between `core_ce` pulses that is not 256, and at least one full period is needed to see it. Stale stop bits or a stale divide setting can only be seen after the next wake-up, on `unit_ce` and `core_ce` in the first running cycle.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    ST_PDOWN = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RUN   = 2'd3
  } pdc_state_e;
endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
  parameter int          STAGES  = 2,
  parameter int          WIDTH   = 2,
  parameter logic [31:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q[g] <= RST_VAL[WIDTH-1:0];
        else if (g == 0) stage_q[g] <= d;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pdc_seq.sv
module pdc_seq
  import pdc_pkg::*;
#(
  parameter int STABLE_CYCLES = 1000000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_pin_n,
  input  logic pd_pin_n,
  input  logic osc_stable,
  output logic osc_en,
  output logic run
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(STABLE_CYCLES);

  pdc_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_done;

  assign cnt_done = (cnt_q == CNT_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PDOWN: if (pd_pin_n) state_d = ST_ARMED;
      ST_ARMED: begin
        if (!pd_pin_n)       state_d = ST_PDOWN;
        else if (!rst_pin_n) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!pd_pin_n) state_d = ST_PDOWN;
        else if (rst_pin_n && cnt_done && osc_stable) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!pd_pin_n)       state_d = ST_PDOWN;
        else if (!rst_pin_n) state_d = ST_WAIT;
      end
      default: state_d = ST_PDOWN;
    endcase
  end

  always_comb begin
    if (state_q != ST_WAIT || state_d != ST_WAIT) cnt_d = '0;
    else if (cnt_done)                            cnt_d = cnt_q;
    else                                          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign osc_en = (state_q == ST_WAIT) || (state_q == ST_RUN);
  assign run    = (state_q == ST_RUN);

  // R1: release only after a completed settling count
  p_hold_until_count_r1: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(run) |-> $past(cnt_done));
  // R8: no release while the oscillator is unstable
  p_wait_stable_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_WAIT && !osc_stable) |=> !run);
  // R2: power-down pin forces the power-down state
  p_pd_enter_r2: assert property (@(posedge clk) disable iff (!arst_n)
    !pd_pin_n |=> (state_q == ST_PDOWN));
  // R3: power-down never wakes straight into the settling wait
  p_no_direct_wake_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_PDOWN) |=> !osc_en);
  // R9: reset pin while running restarts the wait from zero
  p_rerun_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (run && pd_pin_n && !rst_pin_n) |=> (state_q == ST_WAIT && cnt_q == '0));
endmodule

// File: rtl/pdc_div.sv
module pdc_div #(
  parameter int DIV_W = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic en,
  output logic tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick = en && (cnt_q == '1);

  // R4: a tick is never followed by another tick
  p_tick_single_r4: assert property (@(posedge clk) disable iff (!arst_n)
    tick |=> !tick);
  // R4: an enabled counter restarts at zero after a tick
  p_tick_wrap_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (tick && en) |=> (cnt_q == '0));
endmodule

// File: rtl/pwrdn_clk_ctrl.sv
module pwrdn_clk_ctrl #(
  parameter int NUM_UNITS     = 4,
  parameter int STABLE_CYCLES = 1000000,
  parameter int DIV_W         = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic                 ext_rst_n,
  input  logic                 pdwn_n,
  input  logic                 osc_stable,
  input  logic                 fw_div_wr,
  input  logic                 fw_div_on,
  input  logic                 fw_stop_wr,
  input  logic [NUM_UNITS-1:0] fw_stop_mask,
  output logic                 osc_en,
  output logic                 core_rst_n,
  output logic                 core_ce,
  output logic [NUM_UNITS-1:0] unit_ce
);
  logic [1:0]           pins_s;
  logic                 run;
  logic                 div_q, div_d;
  logic [NUM_UNITS-1:0] stop_q, stop_d;
  logic                 tick;

  pdc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(32'h3)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      ({pdwn_n, ext_rst_n}),
    .q      (pins_s)
  );

  pdc_seq #(.STABLE_CYCLES(STABLE_CYCLES)) u_seq (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_pin_n  (pins_s[0]),
    .pd_pin_n   (pins_s[1]),
    .osc_stable (osc_stable),
    .osc_en     (osc_en),
    .run        (run)
  );

  always_comb begin
    div_d  = div_q;
    stop_d = stop_q;
    if (!run) begin
      div_d  = 1'b0;
      stop_d = '0;
    end else begin
      if (fw_div_wr)  div_d  = fw_div_on;
      if (fw_stop_wr) stop_d = fw_stop_mask;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      div_q  <= 1'b0;
      stop_q <= '0;
    end else begin
      div_q  <= div_d;
      stop_q <= stop_d;
    end
  end

  pdc_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .arst_n (arst_n),
    .en     (run && div_q),
    .tick   (tick)
  );

  assign core_rst_n = run;
  assign core_ce    = run && (div_q ? tick : 1'b1);
  assign unit_ce    = {NUM_UNITS{core_ce}} & ~stop_q;

  // R5: a firmware write lands in the stop mask one cycle later
  p_stop_load_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (run && fw_stop_wr) |=> (stop_q == $past(fw_stop_mask)));
  // R6 / R7: settings sit at defaults whenever the core is not running
  p_defaults_r6: assert property (@(posedge clk) disable iff (!arst_n)
    !run |=> (stop_q == '0 && !div_q));
  // R2: no enable reaches the core or units outside the running state
  p_no_ce_r2: assert property (@(posedge clk) disable iff (!arst_n)
    !core_rst_n |-> (!core_ce && unit_ce == '0));
endmodule

// File: tb/pwrdn_clk_ctrl_test.sv
module pwrdn_clk_ctrl_test;
  localparam int N      = 4;
  localparam int STABLE = 40;

  logic         clk = 1'b0;
  logic         arst_n, ext_rst_n, pdwn_n, osc_stable;
  logic         fw_div_wr, fw_div_on, fw_stop_wr;
  logic [N-1:0] fw_stop_mask;
  logic         osc_en, core_rst_n, core_ce;
  logic [N-1:0] unit_ce;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pwrdn_clk_ctrl #(.NUM_UNITS(N), .STABLE_CYCLES(STABLE)) uut (
    .clk(clk), .arst_n(arst_n), .ext_rst_n(ext_rst_n), .pdwn_n(pdwn_n),
    .osc_stable(osc_stable), .fw_div_wr(fw_div_wr), .fw_div_on(fw_div_on),
    .fw_stop_wr(fw_stop_wr), .fw_stop_mask(fw_stop_mask), .osc_en(osc_en),
    .core_rst_n(core_rst_n), .core_ce(core_ce), .unit_ce(unit_ce)
  );

  function automatic logic [N-1:0] exp_units(input logic ce, input logic [N-1:0] stop);
    return {N{ce}} & ~stop;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input string what, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_stop(input logic [N-1:0] m);
    fw_stop_wr = 1'b1; fw_stop_mask = m;
    cyc(1);
    fw_stop_wr = 1'b0;
  endtask

  task automatic wr_div(input logic on);
    fw_div_wr = 1'b1; fw_div_on = on;
    cyc(1);
    fw_div_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k, n_tick, n_u0, n_u1, first, second;
    logic [N-1:0] m;
    void'($urandom(32'h1A2B3C4D));
    arst_n = 1'b0; ext_rst_n = 1'b1; pdwn_n = 1'b1; osc_stable = 1'b0;
    fw_div_wr = 1'b0; fw_div_on = 1'b0; fw_stop_wr = 1'b0; fw_stop_mask = '0;
    cyc(3);
    chk("R1", "core_rst_n in reset", int'(core_rst_n), 0);
    chk("R1", "osc_en in reset", int'(osc_en), 1);
    chk("R2", "unit_ce in reset", int'(unit_ce), 0);
    arst_n = 1'b1;

    // R8: count done but oscillator unstable
    cyc(STABLE + 40);
    chk("R8", "core_rst_n while unstable", int'(core_rst_n), 0);
    osc_stable = 1'b1;
    cyc(2);
    chk("R8", "core_rst_n after stable", int'(core_rst_n), 1);
    chk("R4", "core_ce undivided", int'(core_ce), 1);

    // R1: short pin reset, release time measured from pin assertion
    ext_rst_n = 1'b0;
    k = 0;
    for (int i = 0; i < 500; i++) begin
      if (i == 5) ext_rst_n = 1'b1;
      cyc(1); k++;
      if (k == STABLE - 1) chk("R1", "core_rst_n before count", int'(core_rst_n), 0);
      if (core_rst_n && k > 5) break;
    end
    chk_range("R1", "cycles to release", k, STABLE + 3, STABLE + 5);

    // R9 and R1: long pin reset while running
    ext_rst_n = 1'b0;
    cyc(4);
    chk("R9", "core_rst_n during pin reset", int'(core_rst_n), 0);
    cyc(STABLE + 60);
    ext_rst_n = 1'b1;
    k = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1); k++;
      if (core_rst_n) break;
    end
    chk_range("R1", "release after long reset", k, 2, 4);

    // R5: random stop masks, undivided clock
    for (int i = 0; i < 24; i++) begin
      m = N'($urandom);
      wr_stop(m);
      chk("R5", "unit_ce random mask", int'(unit_ce), int'(exp_units(core_ce, m)));
    end

    // R4 / R5: divided clock with unit 1 stopped
    wr_stop(N'(4'b0010));
    wr_div(1'b1);
    n_tick = 0; n_u0 = 0; n_u1 = 0; first = -1; second = -1;
    for (int i = 0; i < 1024; i++) begin
      if (core_ce) begin
        n_tick++;
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
      if (unit_ce[0]) n_u0++;
      if (unit_ce[1]) n_u1++;
      cyc(1);
    end
    chk("R4", "ticks in 1024 cycles", n_tick, 4);
    chk("R4", "tick spacing", second - first, 256);
    chk("R5", "running unit pulses", n_u0, 4);
    chk("R5", "stopped unit pulses", n_u1, 0);

    // R2: power-down with settings active
    wr_stop(N'(4'b1001));
    pdwn_n = 1'b0;
    cyc(4);
    chk("R2", "osc_en in power-down", int'(osc_en), 0);
    chk("R2", "core_rst_n in power-down", int'(core_rst_n), 0);
    chk("R2", "unit_ce in power-down", int'(unit_ce), 0);

    // R3: reset pulse while power-down pin low has no effect
    ext_rst_n = 1'b0; cyc(6); ext_rst_n = 1'b1;
    cyc(20);
    chk("R3", "osc_en after reset in power-down", int'(osc_en), 0);
    pdwn_n = 1'b1;
    cyc(100);
    chk("R3", "osc_en after pin high only", int'(osc_en), 0);

    // R7: writes ignored while held in reset
    wr_stop('1);
    wr_div(1'b1);
    ext_rst_n = 1'b0; cyc(6); ext_rst_n = 1'b1;
    chk("R3", "osc_en after wake reset", int'(osc_en), 1);
    chk("R3", "core_rst_n at wait start", int'(core_rst_n), 0);
    wr_stop('1);
    wr_div(1'b1);
    cyc(STABLE + 10);
    chk("R3", "core_rst_n after wake", int'(core_rst_n), 1);
    chk("R6", "core_ce after wake", int'(core_ce), 1);
    chk("R6", "unit_ce after wake", int'(unit_ce), int'(exp_units(1'b1, '0)));
    cyc(3);
    chk("R7", "unit_ce unaffected by early writes", int'(unit_ce), int'(exp_units(1'b1, '0)));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule